// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block forms the START and STOP conditions of an I2C master. Software talks to it through one 8-bit status register. The top three bits select the transfer mode and carry a bus-busy request. The lower five bits show flags that neighbouring logic supplies, such as the interrupt-pending flag, arbitration loss and address match. When the interface is enabled and software writes master-transmit mode, the BB bit of that write chooses the condition: BB = 1 gives a START and BB = 0 gives a STOP.

Every timing interval is counted in system clock cycles. A clock-speed select picks either a standard set of counts or a high-speed set. The edge timer covers setup, hold and the byte-clock half-period. A second timer, separate from the first, delays the change of the bus-busy flag. After a START the block clocks out one byte's worth of SCL pulses and then holds SCL low. The bus outputs are open-drain style pull-down enables: a value of 1 pulls the line low, and 0 releases it high.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset the status register reads 0x00, both bus lines are released (`scl_low_o` = `sda_low_o` = 0), the bit counter is 0, and `busy_o` and `done_o` are 0.
- R2: The status bits are, from bit 7 down to bit 0: MST, TRX, BB, PIN, AL, AAS, AD0, LRB. An accepted write stores bits 7:6 only. Bit 5 changes only through the busy timer. Bits 4:0 show `flags_i` as sampled at the previous clock edge, and a write never alters them.
- R3: A write with data[7:5] = 111, accepted while enabled and idle, starts a START. Both lines are released at that write edge. SDA is pulled low T edges later while SCL stays released, and SCL is pulled low a further T edges later.
- R4: The START clears the bit counter to 0. SCL then gives 8 pulses, each T edges low and then T edges released, and the counter steps at the end of each released phase. The sequence ends 18·T edges after the write, with both lines held low and the counter back at 0.
- R5: A write with data[7:5] = 110, accepted while enabled and idle, starts a STOP. At the write edge SCL is released and SDA is pulled low. SDA is released T edges later, and the sequence ends 2·T edges after the write.
- R6: T is 20 cycles in standard mode (`hs_mode_i` = 0) and 10 cycles in high-speed mode. The mode is sampled at the accepted write, and later changes to `hs_mode_i` do not affect the running sequence.
- R7: Bit BB takes the requested value B edges after the accepted write, where B is 12 in standard mode and 6 in high-speed mode.
- R8: With `en_i` = 0, a write still stores MST and TRX, but it starts no sequence and leaves BB unchanged.
- R9: A write that arrives while `busy_o` = 1 is ignored completely. The status bits and the bus waveform are unchanged.
- R10: `busy_o` is 1 from the write edge until the end of the sequence. `done_o` is high for exactly the one cycle after the final edge, and at that point `busy_o` is already 0.
- R11: An enabled write whose data[7:6] is 00, 01 or 10 starts no sequence and leaves BB unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Interface enable |
| hs_mode_i | input | 1 | 1 selects high-speed counts, 0 selects standard counts |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Status register write data |
| flags_i | input | 5 | {PIN, AL, AAS, AD0, LRB} from neighbouring logic |
| status_o | output | 8 | Status register contents |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| bit_cnt_o | output | 3 | Byte clock bit counter |
| busy_o | output | 1 | A condition sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Two things can land in the same cycle. The first is a software write that arrives while a condition sequence is already running. The second is the busy-flag timer updating BB in the middle of that sequence. The bench drives a conflicting write a few cycles into each START and STOP. It then checks, every cycle, that MST/TRX keep their old values, that the waveform follows the undisturbed timing, and that BB still flips exactly B edges after the original write. The bench also toggles the speed select during each sequence, which shows that the sampled counts stay fixed.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int BIT_MST = 7;
    localparam int BIT_TRX = 6;
    localparam int BIT_BB  = 5;
    localparam int FLAG_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_S_SETUP,
        ST_S_HOLD,
        ST_B_LOW,
        ST_B_HIGH,
        ST_P_SETUP,
        ST_P_HOLD
    } cond_state_e;

    typedef struct packed {
        cond_state_e         state;
        logic                mst;
        logic                trx;
        logic                bb;
        logic                bb_tgt;
        logic                hs;
        logic [FLAG_W-1:0]   flags;
        logic                scl_low;
        logic                sda_low;
        logic [2:0]          bits;
        logic                done;
    } cond_regs_t;

endpackage

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         fire
);
    typedef struct packed {
        logic         act;
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.act = 1'b1;
            t_d.cnt = len - 1'b1;
        end else if (t_q.act) begin
            if (t_q.cnt == '0) t_d.act = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign fire = t_q.act && (t_q.cnt == '0);
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int STD_EDGE  = 20,
    parameter int FAST_EDGE = 10,
    parameter int STD_BB    = 12,
    parameter int FAST_BB   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        hs_mode_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_data_i,
    input  logic [4:0]  flags_i,
    output logic [7:0]  status_o,
    output logic        scl_low_o,
    output logic        sda_low_o,
    output logic [2:0]  bit_cnt_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int MAX_E = (STD_EDGE > FAST_EDGE) ? STD_EDGE : FAST_EDGE;
    localparam int MAX_B = (STD_BB > FAST_BB) ? STD_BB : FAST_BB;
    localparam int MAX_V = (MAX_E > MAX_B) ? MAX_E : MAX_B;
    localparam int CW    = $clog2(MAX_V + 1);

    cond_regs_t r_d, r_q;
    logic          seq_load, bb_load, seq_fire, bb_fire;
    logic          hs_now, cond_req;
    logic [CW-1:0] seq_len, bb_len;

    i2c_cond_timer #(.W(CW)) u_seq_tmr (
        .clk(clk), .rst_n(rst_n), .load(seq_load), .len(seq_len), .fire(seq_fire)
    );

    i2c_cond_timer #(.W(CW)) u_bb_tmr (
        .clk(clk), .rst_n(rst_n), .load(bb_load), .len(bb_len), .fire(bb_fire)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.flags = flags_i;
        seq_load  = 1'b0;
        bb_load   = 1'b0;
        hs_now    = (r_q.state == ST_IDLE) ? hs_mode_i : r_q.hs;
        seq_len   = hs_now ? CW'(FAST_EDGE) : CW'(STD_EDGE);
        bb_len    = hs_mode_i ? CW'(FAST_BB) : CW'(STD_BB);
        cond_req  = en_i && wr_data_i[BIT_MST] && wr_data_i[BIT_TRX];

        if (bb_fire) r_d.bb = r_q.bb_tgt;

        unique case (r_q.state)
            ST_IDLE: begin
                if (wr_en_i) begin
                    r_d.mst = wr_data_i[BIT_MST];
                    r_d.trx = wr_data_i[BIT_TRX];
                    if (cond_req) begin
                        seq_load   = 1'b1;
                        bb_load    = 1'b1;
                        r_d.bb_tgt = wr_data_i[BIT_BB];
                        r_d.hs     = hs_mode_i;
                        r_d.scl_low = 1'b0;
                        if (wr_data_i[BIT_BB]) begin
                            r_d.state   = ST_S_SETUP;
                            r_d.sda_low = 1'b0;
                            r_d.bits    = 3'd0;
                        end else begin
                            r_d.state   = ST_P_SETUP;
                            r_d.sda_low = 1'b1;
                        end
                    end
                end
            end
            ST_S_SETUP: if (seq_fire) begin
                r_d.state   = ST_S_HOLD;
                r_d.sda_low = 1'b1;
                seq_load    = 1'b1;
            end
            ST_S_HOLD: if (seq_fire) begin
                r_d.state   = ST_B_LOW;
                r_d.scl_low = 1'b1;
                seq_load    = 1'b1;
            end
            ST_B_LOW: if (seq_fire) begin
                r_d.state   = ST_B_HIGH;
                r_d.scl_low = 1'b0;
                seq_load    = 1'b1;
            end
            ST_B_HIGH: if (seq_fire) begin
                r_d.bits    = r_q.bits + 3'd1;
                r_d.scl_low = 1'b1;
                if (r_q.bits == 3'd7) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.state = ST_B_LOW;
                    seq_load  = 1'b1;
                end
            end
            ST_P_SETUP: if (seq_fire) begin
                r_d.state   = ST_P_HOLD;
                r_d.sda_low = 1'b0;
                seq_load    = 1'b1;
            end
            ST_P_HOLD: if (seq_fire) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status_o  = {r_q.mst, r_q.trx, r_q.bb, r_q.flags};
    assign scl_low_o = r_q.scl_low;
    assign sda_low_o = r_q.sda_low;
    assign bit_cnt_o = r_q.bits;
    assign busy_o    = (r_q.state != ST_IDLE);
    assign done_o    = r_q.done;
endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       wr_en_i,
    input logic [7:0] status_o,
    input logic       scl_low_o,
    input logic       sda_low_o,
    input logic       busy_o,
    input logic       done_o
);
    a_r3_sda_falls_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> !scl_low_o);

    a_r5_sda_rises_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low_o) |-> !scl_low_o);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_en_i) |=> $stable(status_o[7:6]));

    a_r8_disabled_no_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && wr_en_i && !en_i) |=> !busy_o);
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wr_en_i(wr_en_i),
    .status_o(status_o), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .busy_o(busy_o), .done_o(done_o)
);

// File: tb/i2c_cond_gen_bench.sv
module i2c_cond_gen_bench;
    localparam int T_STD = 20, T_HS = 10, B_STD = 12, B_HS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, hs_mode = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [4:0] flags_in = 5'h00;
    logic [7:0] status;
    logic       scl_low, sda_low, busy, done;
    logic [2:0] bit_cnt;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    i2c_cond_gen u_i2c_cond_gen (
        .clk(clk), .rst_n(rst_n), .en_i(en), .hs_mode_i(hs_mode),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .flags_i(flags_in),
        .status_o(status), .scl_low_o(scl_low), .sda_low_o(sda_low),
        .bit_cnt_o(bit_cnt), .busy_o(busy), .done_o(done)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic adv(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // {busy, done, scl_low, sda_low, bit_cnt}
    function automatic logic [6:0] exp_start(int j, int t);
        int p;
        if (j < t)      return 7'b1_0_0_0_000;
        if (j < 2 * t)  return 7'b1_0_0_1_000;
        if (j < 18 * t) begin
            p = (j - 2 * t) / t;
            return {1'b1, 1'b0, 1'((p % 2) == 0), 1'b1, 3'(p / 2)};
        end
        return {1'b0, 1'(j == 18 * t), 1'b1, 1'b1, 3'd0};
    endfunction

    function automatic logic [6:0] exp_stop(int j, int t);
        if (j < t)     return 7'b1_0_0_1_000;
        if (j < 2 * t) return 7'b1_0_0_0_000;
        return {1'b0, 1'(j == 2 * t), 5'b0_0_000};
    endfunction

    function automatic logic exp_bb(int j, int b, logic old_bb, logic new_bb);
        return (j < b) ? old_bb : new_bb;
    endfunction

    task automatic run_seq(bit is_start, bit hs);
        int t, b, last;
        logic old_bb;
        t = hs ? T_HS : T_STD;
        b = hs ? B_HS : B_STD;
        last = is_start ? 18 * t + 2 : 2 * t + 2;
        old_bb = status[5];
        en = 1'b1;
        hs_mode = hs;
        wr(is_start ? 8'hE0 : 8'hC0);
        hs_mode = ~hs; // R6: change after the write must not matter
        for (int j = 0; j <= last; j++) begin
            if (is_start)
                chk("R3 R4 R6 R10 start waveform", 32'({busy, done, scl_low, sda_low, bit_cnt}),
                    32'(exp_start(j, t)));
            else
                chk("R5 R6 R10 stop waveform", 32'({busy, done, scl_low, sda_low, bit_cnt}),
                    32'(exp_stop(j, t)));
            chk("R7 busy flag timing", 32'(status[5]), 32'(exp_bb(j, b, old_bb, is_start)));
            chk("R9 mode bits kept", 32'(status[7:6]), 32'(2'b11));
            if (j == 5) begin
                wr_en = 1'b1;
                wr_data = is_start ? 8'h40 : 8'h80;
            end else begin
                wr_en = 1'b0;
            end
            adv(1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [7:0]  d;
        logic        old_bb;
        void'($urandom(32'h5eed_0c0d));

        // R1 reset state
        adv(3);
        chk("R1 reset outputs", 32'({status, scl_low, sda_low, bit_cnt, busy, done}), 32'h0);
        rst_n = 1'b1;
        adv(2);
        chk("R1 after release", 32'({status, scl_low, sda_low, bit_cnt, busy, done}), 32'h0);

        // R2 flags pass through, write cannot alter bits 5:0
        flags_in = 5'h15;
        wr(8'h3F);
        chk("R2 flags and low bits", 32'(status), 32'h15);
        flags_in = 5'h0A;
        adv(1);
        chk("R2 flags follow", 32'(status[4:0]), 32'h0A);

        // R8 disabled write
        en = 1'b0;
        wr(8'hE0);
        chk("R8 mode stored", 32'(status[7:5]), 32'b110);
        adv(20);
        chk("R8 no sequence", 32'({busy, scl_low, sda_low, status[5]}), 32'h0);

        // R11 other modes
        en = 1'b1;
        wr(8'hA0);
        adv(15);
        chk("R11 mode 10 no sequence", 32'({busy, status[7:5]}), 32'b0100);
        wr(8'h60);
        adv(15);
        chk("R11 mode 01 no sequence", 32'({busy, status[7:5]}), 32'b0010);
        wr(8'h20);
        adv(15);
        chk("R11 mode 00 no sequence", 32'({busy, status[7:5], scl_low, sda_low}), 32'h0);

        // directed sequences
        run_seq(1'b1, 1'b0);
        run_seq(1'b0, 1'b0);
        run_seq(1'b1, 1'b1);
        run_seq(1'b0, 1'b1);
        run_seq(1'b0, 1'b0); // STOP on an idle bus
        run_seq(1'b1, 1'b1);
        run_seq(1'b1, 1'b0); // repeated START

        // random writes that must not start a sequence
        for (int i = 0; i < 30; i++) begin
            rv = $urandom;
            flags_in = rv[4:0];
            d = rv[15:8];
            en = rv[16];
            if (en && d[7:6] == 2'b11) d[7] = 1'b0;
            old_bb = status[5];
            wr(d);
            chk("R2 R8 R11 random write", 32'({busy, status}),
                32'({1'b0, d[7:6], old_bb, rv[4:0]}));
        end

        // random sequences
        for (int i = 0; i < 4; i++) begin
            rv = $urandom;
            run_seq(rv[0], rv[1]);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule